// File: doc/BRIEF.md
# Multi-Channel Toggle-on-Compare Waveform Generator

The block holds one 16-bit base timer and eight output channels that share it. Each channel has its own compare value. When the base timer takes on that value, the channel's internal level flip-flop changes state and the channel's interrupt line pulses. The result is a square wave on each pin. Its phase is set by the compare value and its period by the timer's clear source.

The timer steps only when the one-cycle `tick_i` input is high, so a prescaler outside the block sets the time base. The timer can run free and wrap at 16 bits. It can also be cleared using channel 0's compare value or a dedicated clear register as the limit. Per channel, software can set the enable, the starting level, pin inversion and a hold-after-match option. It can also give the pin to a plain data bit while the waveform keeps running internally. All settings are loaded through a simple write port.

Top module: `toggle_cmp_gen`

## Requirements
- R1: After `rst_ni` is released, `timer_o` is 0, every pin is 0 and every interrupt is 0.
- R2: The timer changes only on cycles with `tick_i` high. With the clear-select field at 0, each tick adds 1 and the timer wraps from FFFFh to 0. A channel's level therefore stays constant for 65536 ticks.
- R3: With clear-select 1, let n be channel 0's compare value. The timer counts 0, 1, …, n+1 and then returns to 0, a period of n+2 ticks.
- R4: With clear-select 2, the same n+2 tick period applies, but n is taken from the clear register.
- R5: An enabled channel flips its level on the clock edge at which a tick loads the timer with that channel's compare value.
- R6: On each such match of an enabled channel, its interrupt bit is high for exactly one cycle, in the cycle after that edge.
- R7: A disabled channel's level does not change on matches, and the channel raises no interrupt.
- R8: A write to the starting-level register loads bit j into channel j's flip-flop only if channel j is disabled. For an enabled channel the write has no effect.
- R9: When a channel's invert bit is 1, its pin shows the complement of its flip-flop.
- R10: With a channel's hold bit at 1, the first match flips the level once. Later matches leave the level unchanged but still raise interrupts. Once hold is cleared, the level flips again at the next match.
- R11: With a channel's output-off bit at 1, its pin shows that channel's data bit. The flip-flop keeps flipping on matches. When output-off returns to 0, the pin shows the current waveform level again.
- R12: Clear-select 3 behaves as free-running.
- R13: Write map, with `wr_addr_i` 0–7 selecting channel 0–7's compare value:
  - 8 selects the clear register.
  - 9 selects clear-select in data bits [1:0].
  - 10 to 15 select per-channel bit vectors, with bit j belonging to channel j: enable at 10, starting level at 11, invert at 12, hold at 13, output-off at 14 and data at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable, one cycle per count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| timer_o | output | 16 | Current base timer value |
| pin_o | output | 8 | Channel output pins |
| irq_o | output | 8 | Per-channel match interrupt pulses |

## Verification
Several properties are checked on every cycle:
- The timer holds between ticks.
- The timer steps by one when free-running or when the clear-select is illegal.
- The timer returns to 0 after the limit plus one in both clear modes.
- Interrupts follow a tick, come only from enabled channels and never last two cycles.

The bench scenarios are needed for the rest:
- the exact edge at which a level flips,
- the 65536-tick phase of a free-running wave,
- a starting-level load that is accepted when the channel is disabled and ignored when enabled,
- inversion,
- the hold freeze and its release,
- output-off showing the data bit while the hidden waveform keeps advancing.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  typedef enum logic [1:0] {
    RS_FREE = 2'b00,
    RS_CH0  = 2'b01,
    RS_REG  = 2'b10,
    RS_BAD  = 2'b11
  } rsel_e;

  // offsets above the per-channel compare block
  localparam int unsigned OFS_RVAL = 0;
  localparam int unsigned OFS_CTRL = 1;
  localparam int unsigned OFS_EN   = 2;
  localparam int unsigned OFS_DFLT = 3;
  localparam int unsigned OFS_INV  = 4;
  localparam int unsigned OFS_HOLD = 5;
  localparam int unsigned OFS_ODIS = 6;
  localparam int unsigned OFS_GPIO = 7;
endpackage

// File: rtl/tcg_regs.sv
module tcg_regs import tcg_pkg::*; #(
  parameter int unsigned NCH = 8,
  parameter int unsigned TW  = 16,
  parameter int unsigned AW  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [TW-1:0]           wr_data_i,
  output logic [NCH-1:0][TW-1:0]  cmp_o,
  output logic [TW-1:0]           rval_o,
  output rsel_e                   rsel_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          dflt_ld_o,
  output logic [NCH-1:0]          dflt_val_o,
  output logic [NCH-1:0]          inv_o,
  output logic [NCH-1:0]          hold_o,
  output logic [NCH-1:0]          odis_o,
  output logic [NCH-1:0]          gpio_o
);
  localparam logic [AW-1:0] A_RVAL = AW'(NCH + OFS_RVAL);
  localparam logic [AW-1:0] A_CTRL = AW'(NCH + OFS_CTRL);
  localparam logic [AW-1:0] A_EN   = AW'(NCH + OFS_EN);
  localparam logic [AW-1:0] A_DFLT = AW'(NCH + OFS_DFLT);
  localparam logic [AW-1:0] A_INV  = AW'(NCH + OFS_INV);
  localparam logic [AW-1:0] A_HOLD = AW'(NCH + OFS_HOLD);
  localparam logic [AW-1:0] A_ODIS = AW'(NCH + OFS_ODIS);
  localparam logic [AW-1:0] A_GPIO = AW'(NCH + OFS_GPIO);

  logic [NCH-1:0] wbits;
  assign wbits = wr_data_i[NCH-1:0];

  for (genvar j = 0; j < NCH; j++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_o[j] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(j)) cmp_o[j] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rval_o <= '0;
      rsel_o <= RS_FREE;
      en_o   <= '0;
      inv_o  <= '0;
      hold_o <= '0;
      odis_o <= '0;
      gpio_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_RVAL:  rval_o <= wr_data_i;
        A_CTRL:  rsel_o <= rsel_e'(wr_data_i[1:0]);
        A_EN:    en_o   <= wbits;
        A_INV:   inv_o  <= wbits;
        A_HOLD:  hold_o <= wbits;
        A_ODIS:  odis_o <= wbits;
        A_GPIO:  gpio_o <= wbits;
        default: ;
      endcase
    end
  end

  // starting level is a strobe into the channel flip-flop, not a stored field
  assign dflt_ld_o  = (wr_en_i && wr_addr_i == A_DFLT) ? {NCH{1'b1}} : '0;
  assign dflt_val_o = wbits;
endmodule

// File: rtl/tcg_base_timer.sv
module tcg_base_timer import tcg_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  rsel_e         rsel_i,
  input  logic [TW-1:0] cmp0_i,
  input  logic [TW-1:0] rval_i,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] cnt_nxt_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  logic          lim_on;
  logic          clr;

  always_comb begin
    unique case (rsel_i)
      RS_CH0:  begin lim = cmp0_i; lim_on = 1'b1; end
      RS_REG:  begin lim = rval_i; lim_on = 1'b1; end
      default: begin lim = '0;     lim_on = 1'b0; end  // free or illegal
    endcase
    // clear one count past the limit: period of lim+2 ticks
    clr       = lim_on && (cnt_q == lim + 1'b1);
    cnt_nxt_o = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tcg_channel.sv
module tcg_channel #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] cnt_nxt_i,
  input  logic [TW-1:0] cmp_i,
  input  logic          en_i,
  input  logic          dflt_ld_i,
  input  logic          dflt_val_i,
  input  logic          inv_i,
  input  logic          hold_i,
  input  logic          odis_i,
  input  logic          gpio_i,
  output logic          pin_o,
  output logic          irq_o
);
  logic match;
  logic lvl_q;
  logic held_q;

  assign match = tick_i && (cnt_nxt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      held_q <= 1'b0;
      irq_o  <= 1'b0;
    end else if (!en_i) begin
      irq_o  <= 1'b0;
      held_q <= 1'b0;
      if (dflt_ld_i) lvl_q <= dflt_val_i;
    end else begin
      irq_o <= match;
      if (match && !(hold_i && held_q)) lvl_q <= ~lvl_q;
      held_q <= hold_i && (held_q || match);
    end
  end

  assign pin_o = odis_i ? gpio_i : (lvl_q ^ inv_i);
endmodule

// File: rtl/toggle_cmp_gen.sv
module toggle_cmp_gen import tcg_pkg::*; #(
  parameter int unsigned NCH = 8,
  parameter int unsigned TW  = 16,
  localparam int unsigned AW = $clog2(NCH) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [TW-1:0]  wr_data_i,
  output logic [TW-1:0]  timer_o,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0][TW-1:0] cmp_q;
  logic [TW-1:0]          rval;
  rsel_e                  rsel;
  logic [NCH-1:0]         ch_en, dflt_ld, dflt_val, inv, hold, odis, gpio;
  logic [TW-1:0]          cnt_nxt;

  tcg_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cmp_o      (cmp_q),
    .rval_o     (rval),
    .rsel_o     (rsel),
    .en_o       (ch_en),
    .dflt_ld_o  (dflt_ld),
    .dflt_val_o (dflt_val),
    .inv_o      (inv),
    .hold_o     (hold),
    .odis_o     (odis),
    .gpio_o     (gpio)
  );

  tcg_base_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rsel_i    (rsel),
    .cmp0_i    (cmp_q[0]),
    .rval_i    (rval),
    .cnt_o     (timer_o),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    tcg_channel #(.TW(TW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_nxt_i  (cnt_nxt),
      .cmp_i      (cmp_q[j]),
      .en_i       (ch_en[j]),
      .dflt_ld_i  (dflt_ld[j]),
      .dflt_val_i (dflt_val[j]),
      .inv_i      (inv[j]),
      .hold_i     (hold[j]),
      .odis_i     (odis[j]),
      .gpio_i     (gpio[j]),
      .pin_o      (pin_o[j]),
      .irq_o      (irq_o[j])
    );
  end
endmodule

// File: rtl/tcg_chk.sv
module tcg_chk import tcg_pkg::*; #(
  parameter int unsigned NCH = 8,
  parameter int unsigned TW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic [TW-1:0]  timer_o,
  input logic [NCH-1:0] irq_o,
  input rsel_e          rsel_i,
  input logic [NCH-1:0] en_i,
  input logic [TW-1:0]  cmp0_i,
  input logic [TW-1:0]  rval_i
);
  // R2
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> timer_o == $past(timer_o));

  // R2 R12
  free_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (rsel_i == RS_FREE || rsel_i == RS_BAD))
      |=> timer_o == TW'($past(timer_o) + 1'b1));

  // R3
  ch0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rsel_i == RS_CH0 && timer_o == TW'(cmp0_i + 1'b1)) |=> timer_o == '0);

  // R4
  reg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rsel_i == RS_REG && timer_o == TW'(rval_i + 1'b1)) |=> timer_o == '0);

  // R6
  irq_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(tick_i));

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(irq_o)) == '0);

  // R7
  irq_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(en_i)) == '0);
endmodule

bind toggle_cmp_gen tcg_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .timer_o (timer_o),
  .irq_o   (irq_o),
  .rsel_i  (rsel),
  .en_i    (ch_en),
  .cmp0_i  (cmp_q[0]),
  .rval_i  (rval)
);

// File: tb/sim_toggle_cmp_gen.sv
module sim_toggle_cmp_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] timer_o;
  logic [7:0]  pin_o;
  logic [7:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  toggle_cmp_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .timer_o(timer_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    wr_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; tick_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cyc(input logic tk);
    tick_i = tk;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) cyc(1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 timer", timer_o, 0);
    check("R1 pins", pin_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_free_wrap();
    do_reset();
    wr(4'd1, 16'd3);
    wr(4'd10, 16'h0002);
    ticks(2);
    check("R2 count", timer_o, 2);
    check("R5 before match", pin_o[1], 0);
    ticks(1);
    check("R5 toggle at match", pin_o[1], 1);
    check("R6 irq pulse", irq_o, 8'h02);
    for (int i = 0; i < 3; i++) cyc(1'b0);
    check("R2 hold without tick", timer_o, 3);
    check("R6 irq one cycle", irq_o, 0);
    ticks(65535);
    check("R2 wrap count", timer_o, 2);
    check("R2 phase not yet over", pin_o[1], 1);
    ticks(1);
    check("R2 phase 65536", pin_o[1], 0);
  endtask

  task automatic t_clear_ch0();
    int e;
    logic p;
    do_reset();
    wr(4'd0, 16'd5);
    wr(4'd9, 16'd1);
    wr(4'd2, 16'd2);
    wr(4'd10, 16'h0004);
    e = 0; p = 1'b0;
    for (int i = 0; i < 20; i++) begin
      ticks(1);
      e = (e == 6) ? 0 : e + 1;
      if (e == 2) p = ~p;
      check("R3 timer sequence", timer_o, e);
      check("R5 level n+2 phase", pin_o[2], p);
    end
  endtask

  task automatic t_clear_reg();
    int e;
    do_reset();
    wr(4'd8, 16'd3);
    wr(4'd0, 16'd1);
    wr(4'd9, 16'd2);
    e = 0;
    for (int i = 0; i < 12; i++) begin
      ticks(1);
      e = (e == 4) ? 0 : e + 1;
      check("R4 timer sequence", timer_o, e);
    end
  endtask

  task automatic t_bad_sel();
    do_reset();
    wr(4'd0, 16'd2);
    wr(4'd8, 16'd2);
    wr(4'd9, 16'd3);
    ticks(8);
    check("R12 illegal select free-runs", timer_o, 8);
  endtask

  task automatic t_disable();
    do_reset();
    wr(4'd8, 16'd4);
    wr(4'd9, 16'd2);
    wr(4'd3, 16'd1);
    wr(4'd11, 16'h0008);
    check("R8 load while disabled", pin_o[3], 1);
    for (int i = 0; i < 3; i++) begin
      ticks(1);
      check("R7 no irq disabled", irq_o, 0);
    end
    check("R7 level held", pin_o[3], 1);
    wr(4'd10, 16'h0008);
    wr(4'd11, 16'h0000);
    check("R8 load ignored while enabled", pin_o[3], 1);
    ticks(4);
    check("R5 toggle after enable", pin_o[3], 0);
    wr(4'd10, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      ticks(1);
      check("R7 no irq after disable", irq_o, 0);
      check("R7 level held after disable", pin_o[3], 0);
    end
  endtask

  task automatic t_invert();
    do_reset();
    wr(4'd12, 16'h0010);
    check("R9 inverted idle", pin_o, 8'h10);
    wr(4'd8, 16'd2);
    wr(4'd9, 16'd2);
    wr(4'd4, 16'd1);
    wr(4'd10, 16'h0010);
    ticks(1);
    check("R9 inverted after toggle", pin_o[4], 0);
    ticks(4);
    check("R9 inverted second toggle", pin_o[4], 1);
  endtask

  task automatic t_hold();
    do_reset();
    wr(4'd8, 16'd3);
    wr(4'd9, 16'd2);
    wr(4'd5, 16'd2);
    wr(4'd10, 16'h0020);
    wr(4'd13, 16'h0020);
    ticks(2);
    check("R10 first match flips", pin_o[5], 1);
    ticks(5);
    check("R10 frozen on later match", pin_o[5], 1);
    check("R10 irq still raised", irq_o[5], 1);
    wr(4'd13, 16'h0000);
    ticks(5);
    check("R10 resumes at next match", pin_o[5], 0);
  endtask

  task automatic t_odis();
    do_reset();
    wr(4'd8, 16'd3);
    wr(4'd9, 16'd2);
    wr(4'd6, 16'd1);
    wr(4'd10, 16'h0040);
    wr(4'd14, 16'h0040);
    wr(4'd15, 16'h0040);
    check("R11 data bit shown", pin_o[6], 1);
    ticks(1);
    check("R11 data bit kept on match", pin_o[6], 1);
    wr(4'd15, 16'h0000);
    check("R11 data bit follows", pin_o[6], 0);
    ticks(10);
    check("R11 irq while off", irq_o[6], 1);
    check("R11 still data bit", pin_o[6], 0);
    wr(4'd14, 16'h0000);
    check("R11 waveform restored", pin_o[6], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_free_wrap();
    t_clear_ch0();
    t_clear_reg();
    t_bad_sel();
    t_disable();
    t_invert();
    t_hold();
    t_odis();
    // R13 map exercised by every scenario's writes
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule